// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the oversampling strobe for a UART transmitter and receiver from one reference clock. A 16-bit integer divisor, written as two bytes, sets the base length of one sample period in reference clocks. A 4-bit fraction in sixteenths adds one extra reference clock to some periods, spread evenly across each run of sixteen. A switchable divide-by-4 prescaler can sit in front of the divider. A 2-bit select sets the oversampling rate to 16x, 8x or 4x, and from it the block produces a bit strobe.

Software programs the block through a small write-only port with four byte addresses. The fraction, the sampling select and the prescaler bit are protected: a write to them takes effect only while an enhancement-unlock bit is set. Every write, accepted or not, restarts the timing chain from zero, so a new setting applies from a clean phase.

Top module: `frac_baud_gen`

## Requirements
- R1: The integer divisor D is {byte at address 1, byte at address 0}. With the prescaler off and the fraction zero, the first sample tick comes D cycles after the write edge, and each later tick comes D cycles after the one before it.
- R2: Control register (address 3) bit 0 selects the prescaler. When it is 1, every sample period is stretched by a factor of 4 in clock cycles. When it is 0, the divider counts every clock.
- R3: Address 2 bits [5:4] select the oversampling ratio N. The value 00 gives 16, 01 gives 8 and 10 gives 4. The reserved value 11 behaves as 16.
- R4: Address 2 bits [3:0] hold the fraction F. The first period after a restart lasts D reference periods. Period k (k >= 2) lasts D + floor((k-1)F/16) - floor((k-2)F/16) reference periods.
- R5: While the integer divisor is zero, sample_tick and bit_tick stay low.
- R6: bit_tick is high exactly together with sample ticks N, 2N, 3N, ... counted from the last restart, and never without sample_tick.
- R7: Address 3 bit 7 is the unlock bit and can always be written. Writes to address 2, and to bit 0 of address 3, are dropped while the stored unlock bit is 0.
- R8: Any write restarts the prescaler, the divider, the fraction accumulator and the tick counter. Both tick outputs are low in the cycle after the write edge.
- R9: Under reset, and afterwards until programmed, both outputs are low. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 divisor low, 1 divisor high, 2 fraction/ratio, 3 control) |
| wr_data | input | 8 | Write data |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle bit strobe, coincident with every Nth sample tick |

## Verification
A wrong count limit, a wrong accumulator carry or a wrong prescaler phase moves a sample tick. A moved tick appears at the ports within one sample period, no later than the sixteenth period after a restart, because the fraction pattern repeats every sixteen periods. A wrong tick counter or ratio decode shows at the first bit strobe, which comes within sixteen ticks. A lost restart or a leaked protected write changes the spacing of every tick that follows. The bench therefore times each tick against the arithmetic period formula across a sweep of divisors, fractions, ratios and prescaler settings.

// File: rtl/bgen_pkg.sv
// Shared types and helpers for the fractional baud generator.
// Assumes byte-wide register writes and a 2-bit oversampling select.
package bgen_pkg;
    localparam int BYTE_W    = 8;
    localparam int OSR_LSB   = 4;
    localparam int PSC_BIT   = 0;
    localparam int UNLOCK_BIT = 7;

    typedef enum logic [1:0] {
        OSR_X16  = 2'b00,
        OSR_X8   = 2'b01,
        OSR_X4   = 2'b10,
        OSR_RSVD = 2'b11
    } osr_sel_e;

    // Number of sample ticks per bit, minus one.
    function automatic int unsigned osr_last(osr_sel_e sel);
        case (sel)
            OSR_X8:  return 7;
            OSR_X4:  return 3;
            default: return 15;
        endcase
    endfunction
endpackage

// File: rtl/bgen_regs.sv
// Configuration registers: divisor bytes, fraction/ratio and control.
// The fraction/ratio register and the prescaler bit accept writes only while
// the stored unlock bit is set. Assumes FRAC_W <= OSR_LSB.
module bgen_regs
    import bgen_pkg::*;
#(
    parameter int DIV_BYTES = 2,
    parameter int FRAC_W    = 4,
    parameter int ADDR_W    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]           wr_data,
    output logic [DIV_BYTES*BYTE_W-1:0] div_o,
    output logic [FRAC_W-1:0]           frac_o,
    output osr_sel_e                    osr_o,
    output logic                        psc4_o,
    output logic                        unlock_o
);
    localparam int FRAC_ADDR = DIV_BYTES;
    localparam int CTRL_ADDR = DIV_BYTES + 1;

    logic              unlock_q;
    logic              psc4_q;
    logic [FRAC_W-1:0] frac_q;
    osr_sel_e          osr_q;

    generate
        for (genvar g = 0; g < DIV_BYTES; g++) begin : g_div_byte
            logic [BYTE_W-1:0] byte_q;
            // Holds divisor byte g, at address g.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    byte_q <= '0;
                else if (wr_en && wr_addr == ADDR_W'(g))
                    byte_q <= wr_data;
            end
            assign div_o[g*BYTE_W +: BYTE_W] = byte_q;
        end
    endgenerate

    // Protected fraction and ratio register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_q <= '0;
            osr_q  <= OSR_X16;
        end else if (wr_en && wr_addr == ADDR_W'(FRAC_ADDR) && unlock_q) begin
            frac_q <= wr_data[FRAC_W-1:0];
            osr_q  <= osr_sel_e'(wr_data[OSR_LSB +: 2]);
        end
    end

    // Control register: the unlock bit is always writable, the prescaler bit only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlock_q <= 1'b0;
            psc4_q   <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) begin
            unlock_q <= wr_data[UNLOCK_BIT];
            if (unlock_q)
                psc4_q <= wr_data[PSC_BIT];
        end
    end

    assign frac_o   = frac_q;
    assign osr_o    = osr_q;
    assign psc4_o   = psc4_q;
    assign unlock_o = unlock_q;
endmodule

// File: rtl/bgen_prescale.sv
// Reference-enable prescaler: passes every clock, or one clock in RATIO.
// Restart clears the phase, so the first enable comes RATIO cycles later.
module bgen_prescale #(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic div_sel,
    output logic ref_en
);
    localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

    logic [CNT_W-1:0] ph_q;

    // Phase counter for the divided reference.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            ph_q <= '0;
        else if (div_sel)
            ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
        else
            ph_q <= '0;
    end

    assign ref_en = div_sel ? (ph_q == LAST) : 1'b1;
endmodule

// File: rtl/bgen_frac_div.sv
// Fractional period divider. Each period lasts DIV reference enables, plus one
// more when the fraction accumulator carries. A zero divisor halts it.
// Output period_end is a single-cycle combinational strobe.
module bgen_frac_div #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              ref_en,
    input  logic [DIV_W-1:0]  div,
    input  logic [FRAC_W-1:0] frac,
    output logic              period_end
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic              extra_q;
    logic [CNT_W-1:0]  limit;
    logic [FRAC_W:0]   acc_sum;
    logic              running;

    // Length of the current period minus one, and the next accumulator value.
    always_comb begin
        running    = (div != '0);
        limit      = CNT_W'(div) - CNT_W'(1) + CNT_W'(extra_q);
        acc_sum    = {1'b0, acc_q} + {1'b0, frac};
        period_end = ref_en && running && (cnt_q == limit);
    end

    // Period counter and fraction accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q   <= '0;
            acc_q   <= '0;
            extra_q <= 1'b0;
        end else if (period_end) begin
            cnt_q   <= '0;
            acc_q   <= acc_sum[FRAC_W-1:0];
            extra_q <= acc_sum[FRAC_W];
        end else if (ref_en && running) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bgen_bit_tick.sv
// Registers the sample strobe and raises the bit strobe on every Nth sample,
// where N comes from the oversampling select. Restart clears the count.
module bgen_bit_tick
    import bgen_pkg::*;
#(
    parameter int MAX_OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  osr_sel_e osr,
    input  logic     period_end,
    output logic     sample_tick,
    output logic     bit_tick
);
    localparam int CNT_W = $clog2(MAX_OSR);

    logic [CNT_W-1:0] os_q;
    logic [CNT_W-1:0] last;
    logic             wrap;

    // Decode the last sample index of a bit.
    always_comb begin
        last = CNT_W'(osr_last(osr));
        wrap = period_end && (os_q == last);
    end

    // Sample counter and the registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            os_q        <= '0;
            sample_tick <= 1'b0;
            bit_tick    <= 1'b0;
        end else begin
            sample_tick <= period_end;
            bit_tick    <= wrap;
            if (wrap)
                os_q <= '0;
            else if (period_end)
                os_q <= os_q + 1'b1;
        end
    end
endmodule

// File: rtl/frac_baud_gen.sv
// Fractional UART baud generator top. A write to any register restarts the
// timing chain. Assumes a single reference clock and synchronous reset.
module frac_baud_gen
    import bgen_pkg::*;
#(
    parameter int DIV_BYTES = 2,
    parameter int FRAC_W    = 4,
    parameter int PSC_RATIO = 4,
    parameter int MAX_OSR   = 16,
    localparam int ADDR_W   = $clog2(DIV_BYTES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              sample_tick,
    output logic              bit_tick
);
    localparam int DIV_W = DIV_BYTES * BYTE_W;

    logic [DIV_W-1:0]  div_w;
    logic [FRAC_W-1:0] frac_w;
    osr_sel_e          osr_w;
    logic              psc4_w;
    logic              unlock_w;
    logic              ref_en_w;
    logic              period_end_w;

    bgen_regs #(.DIV_BYTES(DIV_BYTES), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .div_o(div_w), .frac_o(frac_w), .osr_o(osr_w), .psc4_o(psc4_w), .unlock_o(unlock_w)
    );

    bgen_prescale #(.RATIO(PSC_RATIO)) u_psc (
        .clk(clk), .rst_n(rst_n), .restart(wr_en), .div_sel(psc4_w), .ref_en(ref_en_w)
    );

    bgen_frac_div #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(wr_en), .ref_en(ref_en_w),
        .div(div_w), .frac(frac_w), .period_end(period_end_w)
    );

    bgen_bit_tick #(.MAX_OSR(MAX_OSR)) u_bit (
        .clk(clk), .rst_n(rst_n), .restart(wr_en), .osr(osr_w),
        .period_end(period_end_w), .sample_tick(sample_tick), .bit_tick(bit_tick)
    );
endmodule

// File: rtl/frac_baud_gen_chk.sv
// Assertion checker for frac_baud_gen, bound to every instance of the top.
module frac_baud_gen_chk
    import bgen_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DIV_W     = 16,
    parameter int FRAC_W    = 4,
    parameter int FRAC_ADDR = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              sample_tick,
    input logic              bit_tick,
    input logic [DIV_W-1:0]  div,
    input logic [FRAC_W-1:0] frac,
    input osr_sel_e          osr,
    input logic              psc4,
    input logic              unlock
);
    AST_ZERO_DIV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |-> !sample_tick && !bit_tick); // R5
    AST_BIT_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick); // R6
    AST_WRITE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !sample_tick && !bit_tick); // R8
    AST_LOCKED_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(FRAC_ADDR) && !unlock) |=> $stable(frac) && $stable(osr)); // R7
    AST_PSC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (psc4 && sample_tick) |=> !sample_tick); // R2
endmodule

bind frac_baud_gen frac_baud_gen_chk #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W), .FRAC_ADDR(DIV_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .sample_tick(sample_tick), .bit_tick(bit_tick), .div(div_w), .frac(frac_w),
    .osr(osr_w), .psc4(psc4_w), .unlock(unlock_w)
);

// File: tb/frac_baud_gen_tb.sv
// Self-checking bench: times every sample tick against the period formula.
module frac_baud_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sample_tick;
    logic       bit_tick;
    int         n_vec = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    frac_baud_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic configure(input int d, input int f, input int osr, input int psc);
        wr(3, 8'h80);
        wr(3, 8'h80 | psc);
        wr(2, (osr << 4) | f);
        wr(1, d >> 8);
        wr(0, d & 8'hFF);
    endtask

    // Time K ticks after the last write, and check the bit strobe on each tick.
    task automatic measure(input int d, input int f, input int osr, input int psc,
                           input int kmax, input string req);
        int n = 0;
        int exp_t = 0;
        int p = psc ? 4 : 1;
        int ratio = (osr == 1) ? 8 : (osr == 2) ? 4 : 16;
        for (int k = 1; k <= kmax; k++) begin
            if (k == 1) exp_t += p * d;
            else        exp_t += p * (d + ((k - 1) * f) / 16 - ((k - 2) * f) / 16);
            do begin
                @(negedge clk);
                n++;
            end while (!sample_tick && n <= exp_t + 8 * p);
            check(n == exp_t, req, n, exp_t);
            check(bit_tick == ((k % ratio) == 0), "R6", int'(bit_tick), int'((k % ratio) == 0));
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        // R9: reset state, and no ticks before programming
        repeat (3) begin
            @(negedge clk);
            check(!sample_tick && !bit_tick, "R9", int'(sample_tick | bit_tick), 0);
        end
        rst_n = 1'b1;
        cnt = 0;
        repeat (50) begin @(negedge clk); cnt += int'(sample_tick | bit_tick); end
        check(cnt == 0, "R9", cnt, 0);

        // R1 R2 R3 R4: sweep of small divisors, every fraction, ratios, prescaler
        for (int psc = 0; psc < 2; psc++)
            for (int osr = 0; osr < 3; osr++)
                for (int d = 1; d <= 3; d++)
                    for (int f = 0; f < 16; f++) begin
                        configure(d, f, osr, psc);
                        measure(d, f, osr, psc, 16, psc ? "R2" : "R4");
                    end

        // R4: divisor 156.25
        configure(156, 4, 0, 0);
        measure(156, 4, 0, 0, 20, "R4");
        // R1: high byte in use
        configure(258, 8, 2, 1);
        measure(258, 8, 2, 1, 4, "R1");
        // R3: reserved ratio code acts as 16x
        configure(2, 0, 3, 0);
        measure(2, 0, 3, 0, 32, "R3");

        // R5: zero divisor keeps outputs low
        configure(0, 5, 2, 0);
        cnt = 0;
        repeat (200) begin @(negedge clk); cnt += int'(sample_tick | bit_tick); end
        check(cnt == 0, "R5", cnt, 0);

        // R7: locked writes to fraction/ratio and prescaler are dropped
        configure(3, 0, 0, 0);
        wr(3, 8'h00);
        wr(3, 8'h01);
        wr(2, 8'h15);
        wr(0, 3);
        measure(3, 0, 0, 0, 32, "R7");

        // R8: a write in mid-period restarts the phase
        configure(5, 3, 1, 0);
        repeat (7) @(negedge clk);
        wr(1, 0);
        measure(5, 3, 1, 0, 16, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule